// File: doc/BRIEF.md
# RS-485 Half-Duplex Transmit Direction Controller

This block sits beside one UART channel and decides when that channel owns a shared half-duplex line. It watches the transmit FIFO fill level and the shift-register-empty flag. From these it drives the enable pin of an external RS-485 line driver. After the last bit has left the shift register, it keeps that enable asserted for a programmable number of bit times, so the final stop bit is not cut off before the line turns around.

The same mode bits also shape three other signals. The transmitter interrupt can be deferred until the channel has gone completely idle, which suits short packets, or it can follow the usual FIFO threshold rule, which suits long blocks. The serial receiver is switched off while the channel transmits, so the node does not capture its own echo, unless snooping is requested. The character-timeout interrupt is permitted only when snooping is set.

All outputs except the hold-off timer are combinational functions of the inputs and of the timer state. The UART datapath, FIFOs and baud generator are outside this block. There is no streaming data interface, so every pin is a plain level.

Top module: `txdir_ctrl`

## Requirements
- R1: After reset, and in any cycle where `rs485_en` is low, `drv_en` is low. Clearing `rs485_en` drops `drv_en` in the same cycle and discards any pending hold-off.
- R2: While `rs485_en` is high and the channel is busy, `drv_en` is high in the same cycle. Busy means `tx_level` is non-zero or `tsr_empty` is low.
- R3: When the channel stops being busy, `drv_en` stays high until the clock edge that samples the N-th `bit_tick` pulse after that point, and is low from the next cycle on. N is the value of `hold_code` (0..7). With N = 0, `drv_en` falls in the same cycle that busy falls.
- R4: `bit_tick` pulses that arrive while the channel is busy do not count toward the hold-off.
- R5: If new data makes the channel busy while the hold-off is counting, the count is discarded and `drv_en` stays high. The next idle period counts the full N ticks again.
- R6: With `rs485_en` high and `big_block` low, `tx_irq` is high exactly when the channel is not busy.
- R7: In every other mode, `tx_irq` is high when `tx_level` is zero or when `tx_level` is below `tx_thresh`.
- R8: With both `rs485_en` and `ir_en` low, `rx_en` is high.
- R9: With `rs485_en` or `ir_en` high and `rx_snoop` low, `rx_en` is low while the channel is busy or `drv_en` is high, and high otherwise. With `rx_snoop` high, `rx_en` is always high.
- R10: `rx_tmo_en` equals `rx_snoop` in every mode, including full-duplex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rs485_en | input | 1 | Half-duplex line-driver mode |
| big_block | input | 1 | Use threshold-based TX interrupt in RS-485 mode |
| rx_snoop | input | 1 | Keep receiver listening while transmitting |
| ir_en | input | 1 | Infrared half-duplex mode |
| hold_code | input | DLY_W (3) | Hold-off length in bit ticks |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_level | input | LVL_W (7) | Transmit FIFO/holding register fill level |
| tx_thresh | input | LVL_W (7) | Transmit FIFO interrupt threshold |
| tsr_empty | input | 1 | Transmit shift register is empty |
| drv_en | output | 1 | Line-driver enable |
| tx_irq | output | 1 | Transmitter interrupt request |
| rx_en | output | 1 | Serial receiver enable |
| rx_tmo_en | output | 1 | Character-timeout interrupt permit |

## Verification
Two events can meet in the same cycle. The first is the hold-off expiry, where a `bit_tick` completes the count. The second is a new transmission, which restarts the hold. The bench provokes this by re-filling the FIFO partway through a hold. It then checks that `drv_en` never drops and that the next idle period lasts the full programmed length, and it also feeds ticks while busy to show they are ignored. A second overlap is `rx_en` versus `drv_en` during the hold tail: the receiver must stay off until the exact cycle the driver releases. The bench judges this by sampling both outputs on every cycle of each swept hold length.

// File: rtl/txdir_pkg.sv
package txdir_pkg;
  localparam int unsigned DLY_W_DEF = 3;
  localparam int unsigned LVL_W_DEF = 7;

  typedef struct packed {
    logic rs485;
    logic big_block;
    logic snoop;
    logic irda;
  } hdx_mode_t;
endpackage

// File: rtl/txdir_hold.sv
module txdir_hold #(
  parameter int unsigned DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             busy,
  input  logic             tick,
  input  logic [DLY_W-1:0] code,
  output logic             hold
);
  localparam int unsigned CW = DLY_W + 1;

  logic             hold_q;
  logic [DLY_W-1:0] cnt_q;
  logic [CW-1:0]    cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + CW'(1);
  assign hold    = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!enable) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy) begin
      hold_q <= (code != '0);
      cnt_q  <= '0;
    end else if (hold_q && tick) begin
      if (cnt_inc >= {1'b0, code}) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_inc[DLY_W-1:0];
      end
    end
  end

  // Ticks absent while idle: the count must not move.
  assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enable && hold_q && !busy && !tick |=> $stable(cnt_q) && hold_q);

  // A busy cycle discards any partial count.
  assert_busy_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    enable && busy |=> cnt_q == '0);

  // Ticks during busy never leave a count behind.
  assert_busy_tick_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enable && busy && tick |=> cnt_q == '0);
endmodule

// File: rtl/txdir_irq.sv
module txdir_irq #(
  parameter int unsigned LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rs485,
  input  logic             big_block,
  input  logic             busy,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  input  logic             tsr_empty,
  output logic             irq
);
  logic below_thr;
  logic defer;

  assign below_thr = (level == '0) || (level < thresh);
  assign defer     = rs485 && !big_block;

  always_comb begin
    if (defer) irq = !busy;
    else       irq = below_thr;
  end

  // Deferred mode: an interrupt implies the shift register has drained.
  assert_irq_deferred_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rs485 && !big_block && irq |-> tsr_empty && level == '0);

  // Threshold mode: an empty FIFO always requests service.
  assert_irq_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rs485 && !big_block) && level == '0 |-> irq);
endmodule

// File: rtl/txdir_rxgate.sv
module txdir_rxgate (
  input  logic clk,
  input  logic rst_n,
  input  logic rs485,
  input  logic irda,
  input  logic snoop,
  input  logic tx_active,
  output logic rx_en,
  output logic tmo_en
);
  logic half_duplex;

  assign half_duplex = rs485 || irda;

  always_comb begin
    if (!half_duplex || snoop) rx_en = 1'b1;
    else                       rx_en = !tx_active;
  end

  assign tmo_en = snoop;

  assert_rx_fullduplex_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rs485 && !irda |-> rx_en);

  assert_rx_snoop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snoop |-> rx_en && tmo_en);
endmodule

// File: rtl/txdir_ctrl.sv
module txdir_ctrl
  import txdir_pkg::*;
#(
  parameter int unsigned DLY_W = DLY_W_DEF,
  parameter int unsigned LVL_W = LVL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rs485_en,
  input  logic             big_block,
  input  logic             rx_snoop,
  input  logic             ir_en,
  input  logic [DLY_W-1:0] hold_code,
  input  logic             bit_tick,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic             tsr_empty,
  output logic             drv_en,
  output logic             tx_irq,
  output logic             rx_en,
  output logic             rx_tmo_en
);
  hdx_mode_t mode;
  logic      busy;
  logic      hold;
  logic      tx_active;

  assign mode      = '{rs485: rs485_en, big_block: big_block, snoop: rx_snoop, irda: ir_en};
  assign busy      = (tx_level != '0) || !tsr_empty;
  assign drv_en    = mode.rs485 && (busy || hold);
  assign tx_active = busy || drv_en;

  txdir_hold #(.DLY_W(DLY_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (mode.rs485),
    .busy   (busy),
    .tick   (bit_tick),
    .code   (hold_code),
    .hold   (hold)
  );

  txdir_irq #(.LVL_W(LVL_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rs485     (mode.rs485),
    .big_block (mode.big_block),
    .busy      (busy),
    .level     (tx_level),
    .thresh    (tx_thresh),
    .tsr_empty (tsr_empty),
    .irq       (tx_irq)
  );

  txdir_rxgate u_rxgate (
    .clk       (clk),
    .rst_n     (rst_n),
    .rs485     (mode.rs485),
    .irda      (mode.irda),
    .snoop     (mode.snoop),
    .tx_active (tx_active),
    .rx_en     (rx_en),
    .tmo_en    (rx_tmo_en)
  );

  assert_drv_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rs485_en |-> !drv_en);

  assert_drv_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rs485_en && ((tx_level != '0) || !tsr_empty) |-> drv_en);

  // With a non-zero code, the driver only releases after a sampled tick.
  assert_drv_fall_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rs485_en && $past(rs485_en) && $fell(drv_en) && $past(hold_code) != '0
      |-> $past(bit_tick));

  // Receiver stays off while the driver owns the line, unless snooping.
  assert_rx_off_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en && !rx_snoop |-> !rx_en);
endmodule

// File: tb/txdir_ctrl_bench.sv
module txdir_ctrl_bench;
  localparam int DLY_W = 3;
  localparam int LVL_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rs485_en = 1'b0, big_block = 1'b0, rx_snoop = 1'b0, ir_en = 1'b0;
  logic [DLY_W-1:0] hold_code = '0;
  logic             bit_tick = 1'b0;
  logic [LVL_W-1:0] tx_level = '0, tx_thresh = '0;
  logic             tsr_empty = 1'b1;
  logic             drv_en, tx_irq, rx_en, rx_tmo_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  txdir_ctrl #(.DLY_W(DLY_W), .LVL_W(LVL_W)) u_txdir_ctrl (
    .clk(clk), .rst_n(rst_n), .rs485_en(rs485_en), .big_block(big_block),
    .rx_snoop(rx_snoop), .ir_en(ir_en), .hold_code(hold_code), .bit_tick(bit_tick),
    .tx_level(tx_level), .tx_thresh(tx_thresh), .tsr_empty(tsr_empty),
    .drv_en(drv_en), .tx_irq(tx_irq), .rx_en(rx_en), .rx_tmo_en(rx_tmo_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Runs one transmission then an idle tail with ticks every 3rd cycle;
  // returns cycles the driver stays on after busy falls.
  task automatic tail_len(input int code, output int hi);
    hold_code = DLY_W'(code);
    rs485_en = 1'b1;
    cyc(); tx_level = 7'd3; tsr_empty = 1'b0;
    for (int i = 0; i < 6; i++) begin
      cyc(); bit_tick = (i % 2 == 0); #1;
      chk(drv_en == 1'b1, "R2", drv_en, 1);
      chk(rx_en == 1'b0, "R9", rx_en, 0);
    end
    cyc(); tx_level = '0; tsr_empty = 1'b1; bit_tick = 1'b0;
    hi = 0;
    for (int i = 0; i < 30; i++) begin
      if (i > 0) cyc();
      bit_tick = (i % 3 == 2); #1;
      if (drv_en) hi++;
      chk(rx_en == !drv_en, "R9", rx_en, !drv_en);
    end
    bit_tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int hi;
    repeat (3) @(posedge clk);
    #1;
    chk(drv_en == 1'b0, "R1", drv_en, 0);
    chk(rx_en == 1'b1, "R8", rx_en, 1);
    chk(rx_tmo_en == 1'b0, "R10", rx_tmo_en, 0);
    cyc(); rst_n = 1'b1;

    // Sweep: all modes x levels x thresholds x shift-register state, code 0.
    hold_code = '0;
    for (int m = 0; m < 16; m++) begin
      for (int lv = 0; lv < 9; lv++) begin
        for (int th = 0; th < 9; th++) begin
          for (int te = 0; te < 2; te++) begin
            bit exp_busy, exp_drv, exp_irq, exp_rx;
            cyc();
            rs485_en = m[0]; big_block = m[1]; rx_snoop = m[2]; ir_en = m[3];
            tx_level = LVL_W'(lv); tx_thresh = LVL_W'(th); tsr_empty = te[0];
            #1;
            exp_busy = (lv != 0) || (te == 0);
            exp_drv  = m[0] && exp_busy;
            exp_irq  = (m[0] && !m[1]) ? !exp_busy : ((lv == 0) || (lv < th));
            exp_rx   = (!(m[0] || m[3]) || m[2]) ? 1'b1 : !(exp_busy || exp_drv);
            if (m[0]) chk(drv_en == exp_drv, "R2", drv_en, exp_drv);
            else      chk(drv_en == 1'b0, "R1", drv_en, 0);
            if (m[0] && !m[1]) chk(tx_irq == exp_irq, "R6", tx_irq, exp_irq);
            else               chk(tx_irq == exp_irq, "R7", tx_irq, exp_irq);
            if (!(m[0] || m[3])) chk(rx_en == 1'b1, "R8", rx_en, 1);
            else                 chk(rx_en == exp_rx, "R9", rx_en, exp_rx);
            chk(rx_tmo_en == m[2], "R10", rx_tmo_en, m[2]);
          end
        end
      end
    end

    // Hold-off length for every code; ticks during busy must not count (R4).
    rs485_en = 1'b1; big_block = 1'b0; rx_snoop = 1'b0; ir_en = 1'b0;
    tx_level = '0; tsr_empty = 1'b1;
    for (int c = 0; c < 8; c++) begin
      tail_len(c, hi);
      chk(hi == 3 * c, (c == 0) ? "R3" : "R3/R4", hi, 3 * c);
    end

    // Cancel during hold: code 5, two ticks, then new data, then full tail.
    hold_code = 3'd5;
    cyc(); tx_level = 7'd1; tsr_empty = 1'b0;
    cyc(); tx_level = '0; tsr_empty = 1'b1;
    for (int i = 0; i < 6; i++) begin
      cyc(); bit_tick = (i % 3 == 2); #1;
      chk(drv_en == 1'b1, "R5", drv_en, 1);
    end
    cyc(); bit_tick = 1'b1; tx_level = 7'd2; #1;
    chk(drv_en == 1'b1, "R5", drv_en, 1);
    cyc(); bit_tick = 1'b0; tx_level = '0; tsr_empty = 1'b0; #1;
    chk(drv_en == 1'b1, "R5", drv_en, 1);
    cyc(); tsr_empty = 1'b1;
    hi = 0;
    for (int i = 0; i < 30; i++) begin
      if (i > 0) cyc();
      bit_tick = (i % 3 == 2); #1;
      if (drv_en) hi++;
    end
    bit_tick = 1'b0;
    chk(hi == 15, "R5", hi, 15);

    // Mode cleared mid-hold drops driver at once and discards the hold.
    hold_code = 3'd7;
    cyc(); tx_level = 7'd1;
    cyc(); tx_level = '0;
    cyc(); #1;
    chk(drv_en == 1'b1, "R3", drv_en, 1);
    rs485_en = 1'b0; #1;
    chk(drv_en == 1'b0, "R1", drv_en, 0);
    cyc(); cyc(); rs485_en = 1'b1; #1;
    chk(drv_en == 1'b0, "R1", drv_en, 0);

    // Reset during hold clears it.
    cyc(); tx_level = 7'd1;
    cyc(); tx_level = '0; rst_n = 1'b0; #1;
    chk(drv_en == 1'b0, "R1", drv_en, 0);
    cyc(); rst_n = 1'b1; #1;
    chk(drv_en == 1'b0, "R1", drv_en, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule